// File: doc/BRIEF.md
# Boundary Cell Signature and Pattern Register

This block is a test-clock-driven boundary register that wraps the I/O of a bidirectional bus device. Each of the `PINS` I/O pins has two cells. The input-side cell observes the value present at the pin. The output-side cell sets the value that is forced onto the pin. Together the cells form one serial chain from `tdi` to `tdo`. A separate update stage holds the value that is forced onto the pins in the forcing modes.

A 3-bit mode input takes the place of the decoded test instruction. Besides plain capture, shift and update, the register can do several things while a run-enable input is high. It can sample inputs while toggling outputs. It can compact the sampled inputs into a masked parallel signature. It can step the output cells as a maximal-length pseudo-random generator or as a binary counter. It can also run signature compaction and counting together. In the pass-through modes the normal data path reaches the pins untouched, whatever the register holds. A test controller drives the capture, shift, update and run strobes.

Top module: `boundary_sigpat_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every input cell, output cell and update-stage bit to 0. After reset `tdo` is 0, and a forcing mode drives 0 on `pin_out`.
- R2: When `shift_en` is high, the chain shifts one place per clock from `tdi` toward `tdo`, in this order: `tdi` → output cell PINS-1 … output cell 0 → input cell PINS-1 … input cell 0 → `tdo`. `tdo` always shows input cell 0. After 2·PINS shifts, bit i of a word fed LSB first sits at chain position i, where positions 0..PINS-1 are the input cells and positions PINS..2·PINS-1 are the output cells.
- R3: When `capture_en` is high and `shift_en` is low, the input cells load `sys_in` and the output cells load `sys_out`.
- R4: A high `update_en` copies the output cells into the update stage, unless a run step writes the update stage in that cycle. In the forcing modes `pin_out` equals the update stage. The forcing modes are: 2 toggle, 3 signature, 4 pattern, 5 count and 6 signature+count.
- R5: Mode 0 (normal), mode 1 (sample) and the unused code 7 pass `sys_out` to `pin_out`. In these modes run steps leave all cells unchanged.
- R6: In mode 2, a run step loads `sys_in` into the input cells and writes the inverse of the output cells into both the output cells and the update stage.
- R7: In mode 3, a run step replaces the input cells with S' = {S[PINS-2:0], fb} XOR (`sys_in` AND NOT `sig_mask`), where fb is the XOR of the S bits that are set in `TAPS`. A set mask bit keeps that input out of the signature.
- R8: In mode 4, a run step replaces the output cells and the update stage with {O[PINS-2:0], fb}, where fb is the XOR of the O bits selected by `TAPS`. The default taps 0xB8 select bits 7, 5, 4 and 3, so a nonzero seed repeats only after 255 steps.
- R9: In mode 5, a run step writes O+1 (modulo 2^PINS) into the output cells and the update stage, so 0xFF wraps to 0x00.
- R10: In mode 6, one run step performs both the R7 signature step on the input cells and the R9 count step on the output cells.
- R11: A run step happens only when `run_en` is high and both `shift_en` and `capture_en` are low. Shifting outranks capture, and capture outranks a run step.
- R12: When all four strobes are low, the cells and the update stage hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Operating mode code (see R4, R5) |
| shift_en | input | 1 | Shift the chain one place |
| capture_en | input | 1 | Load pin and core values into the cells |
| update_en | input | 1 | Copy output cells to the update stage |
| run_en | input | 1 | Allow one mode step per clock |
| tdi | input | 1 | Serial chain input |
| sys_in | input | PINS | Values seen at the input pins |
| sys_out | input | PINS | Normal-path data headed for the pins |
| sig_mask | input | PINS | 1 excludes that input from the signature |
| pin_out | output | PINS | Value driven toward the pins |
| tdo | output | 1 | Serial chain output |

## Verification
Chain order is checked with an asymmetric 16-bit word, so that a reversed or rotated chain shows up. The signature is computed over a random input sequence three times: once as is, once with a masked bit flipped, and once with an unmasked bit flipped. The first two results must match and the third must differ, which separates a working mask from a missing one or an inverted one. The pattern generator is seeded with 1 and must return to 1 after exactly 255 steps and not earlier, which rules out a wrong tap set. Counting across the top value, toggling, and collisions between strobes are tried directly. A long random mix of modes and strobes is then compared cycle by cycle against a bench model.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        BM_NORMAL = 3'd0,
        BM_SAMPLE = 3'd1,
        BM_TOGGLE = 3'd2,
        BM_SIG    = 3'd3,
        BM_PRPG   = 3'd4,
        BM_COUNT  = 3'd5,
        BM_SIGCNT = 3'd6
    } bsr_mode_e;

    typedef struct packed {
        logic samp_step;
        logic sig_step;
        logic tog_step;
        logic prpg_step;
        logic cnt_step;
        logic force_pins;
    } step_ops_t;

    function automatic logic mode_forces(input logic [2:0] m);
        return (m >= 3'd2) && (m <= 3'd6);
    endfunction

endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import bsr_pkg::*;
(
    input  logic [2:0] mode,
    input  logic       shift_en,
    input  logic       capture_en,
    input  logic       run_en,
    output step_ops_t  ops
);
    logic      step;
    bsr_mode_e m;

    assign step = run_en & ~shift_en & ~capture_en;
    assign m    = bsr_mode_e'(mode);

    always_comb begin
        ops            = '0;
        ops.force_pins = mode_forces(mode);
        case (m)
            BM_TOGGLE: begin
                ops.samp_step = step;
                ops.tog_step  = step;
            end
            BM_SIG:    ops.sig_step  = step;
            BM_PRPG:   ops.prpg_step = step;
            BM_COUNT:  ops.cnt_step  = step;
            BM_SIGCNT: begin
                ops.sig_step = step;
                ops.cnt_step = step;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bsr_in_bank.sv
module bsr_in_bank #(
    parameter int               PINS = 8,
    parameter logic [PINS-1:0]  TAPS = 8'hB8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            shift_in,
    input  logic            sig_step,
    input  logic            samp_step,
    input  logic [PINS-1:0] sys_in,
    input  logic [PINS-1:0] sig_mask,
    output logic [PINS-1:0] cells
);
    logic [PINS-1:0] sig_next;
    logic [PINS-1:0] gated_in;
    logic            fb;

    assign fb = ^(cells & TAPS);

    genvar g;
    generate
        for (g = 0; g < PINS; g++) begin : g_sig
            assign gated_in[g] = sys_in[g] & ~sig_mask[g];
            if (g == 0) begin : g_lsb
                assign sig_next[g] = fb ^ gated_in[g];
            end else begin : g_up
                assign sig_next[g] = cells[g-1] ^ gated_in[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            cells <= '0;
        else if (shift_en)
            cells <= {shift_in, cells[PINS-1:1]};
        else if (capture_en)
            cells <= sys_in;
        else if (sig_step)
            cells <= sig_next;
        else if (samp_step)
            cells <= sys_in;
    end
endmodule

// File: rtl/bsr_out_bank.sv
module bsr_out_bank #(
    parameter int               PINS = 8,
    parameter logic [PINS-1:0]  TAPS = 8'hB8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            update_en,
    input  logic            tdi,
    input  logic            tog_step,
    input  logic            prpg_step,
    input  logic            cnt_step,
    input  logic [PINS-1:0] sys_out,
    output logic [PINS-1:0] cells,
    output logic [PINS-1:0] upd
);
    localparam logic [PINS-1:0] ONE = {{(PINS-1){1'b0}}, 1'b1};

    logic [PINS-1:0] nxt;
    logic            any_step;

    assign any_step = tog_step | prpg_step | cnt_step;

    always_comb begin
        nxt = cells;
        if (tog_step)
            nxt = ~cells;
        else if (prpg_step)
            nxt = {cells[PINS-2:0], ^(cells & TAPS)};
        else if (cnt_step)
            nxt = cells + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cells <= '0;
        else if (shift_en)
            cells <= {tdi, cells[PINS-1:1]};
        else if (capture_en)
            cells <= sys_out;
        else if (any_step)
            cells <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst)
            upd <= '0;
        else if (any_step)
            upd <= nxt;
        else if (update_en)
            upd <= cells;
    end
endmodule

// File: rtl/boundary_sigpat_reg.sv
module boundary_sigpat_reg
    import bsr_pkg::*;
#(
    parameter int               PINS = 8,
    parameter logic [PINS-1:0]  TAPS = 8'hB8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      mode,
    input  logic            shift_en,
    input  logic            capture_en,
    input  logic            update_en,
    input  logic            run_en,
    input  logic            tdi,
    input  logic [PINS-1:0] sys_in,
    input  logic [PINS-1:0] sys_out,
    input  logic [PINS-1:0] sig_mask,
    output logic [PINS-1:0] pin_out,
    output logic            tdo
);
    step_ops_t       ops;
    logic [PINS-1:0] in_q;
    logic [PINS-1:0] out_q;
    logic [PINS-1:0] upd_q;

    bsr_ctrl u_ctrl (
        .mode       (mode),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .run_en     (run_en),
        .ops        (ops)
    );

    bsr_in_bank #(.PINS(PINS), .TAPS(TAPS)) u_in (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .shift_in   (out_q[0]),
        .sig_step   (ops.sig_step),
        .samp_step  (ops.samp_step),
        .sys_in     (sys_in),
        .sig_mask   (sig_mask),
        .cells      (in_q)
    );

    bsr_out_bank #(.PINS(PINS), .TAPS(TAPS)) u_out (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .capture_en (capture_en),
        .update_en  (update_en),
        .tdi        (tdi),
        .tog_step   (ops.tog_step),
        .prpg_step  (ops.prpg_step),
        .cnt_step   (ops.cnt_step),
        .sys_out    (sys_out),
        .cells      (out_q),
        .upd        (upd_q)
    );

    assign pin_out = ops.force_pins ? upd_q : sys_out;
    assign tdo     = in_q[0];
endmodule

// File: rtl/boundary_sigpat_reg_chk.sv
module boundary_sigpat_reg_chk #(
    parameter int PINS = 8
) (
    input logic            clk,
    input logic            rst,
    input logic [2:0]      mode,
    input logic            shift_en,
    input logic            capture_en,
    input logic            update_en,
    input logic            run_en,
    input logic [PINS-1:0] sys_out,
    input logic [PINS-1:0] pin_out,
    input logic            tdo,
    input logic [PINS-1:0] in_q,
    input logic [PINS-1:0] out_q,
    input logic [PINS-1:0] upd_q
);
    logic step;
    assign step = run_en && !shift_en && !capture_en;

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tdo && upd_q == '0));

    // R5
    pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'd0 || mode == 3'd1 || mode == 3'd7) |-> pin_out == sys_out);

    // R6
    toggle_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == 3'd2) |=> upd_q == ~$past(out_q));

    // R9
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (step && mode == 3'd5) |=> upd_q == ($past(out_q) + {{(PINS-1){1'b0}}, 1'b1}));

    // R11
    shift_pri_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> in_q == {$past(out_q[0]), $past(in_q[PINS-1:1])});

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !capture_en && !update_en && !run_en)
        |=> ($stable(in_q) && $stable(out_q) && $stable(upd_q)));
endmodule

bind boundary_sigpat_reg boundary_sigpat_reg_chk #(.PINS(PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .run_en     (run_en),
    .sys_out    (sys_out),
    .pin_out    (pin_out),
    .tdo        (tdo),
    .in_q       (in_q),
    .out_q      (out_q),
    .upd_q      (upd_q)
);

// File: tb/sim_boundary_sigpat_reg.sv
`timescale 1ns/1ps
module sim_boundary_sigpat_reg;
    localparam int        P  = 8;
    localparam logic [7:0] TP = 8'hB8;

    logic clk = 1'b0;
    logic rst, shift_en, capture_en, update_en, run_en, tdi;
    logic [2:0] mode;
    logic [7:0] sys_in, sys_out, sig_mask;
    logic [7:0] pin_out;
    logic       tdo;

    int nchk = 0;
    int nerr = 0;
    bit mdl_ok = 0;
    string tag = "R5";
    logic [7:0] m_in, m_out, m_upd;

    always #10 clk = ~clk;

    boundary_sigpat_reg #(.PINS(P), .TAPS(TP)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .run_en(run_en),
        .tdi(tdi), .sys_in(sys_in), .sys_out(sys_out), .sig_mask(sig_mask),
        .pin_out(pin_out), .tdo(tdo)
    );

    task automatic chk(input string t, input logic [15:0] got, input logic [15:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s got %h expected %h at %0t", t, got, exp, $time);
        end
    endtask

    function automatic logic [7:0] f_sig(input logic [7:0] s, input logic [7:0] d, input logic [7:0] mk);
        return {s[6:0], ^(s & TP)} ^ (d & ~mk);
    endfunction

    function automatic logic [7:0] f_prpg(input logic [7:0] s);
        return {s[6:0], ^(s & TP)};
    endfunction

    function automatic bit forcing(input logic [2:0] m);
        return (m >= 3'd2) && (m <= 3'd6);
    endfunction

    task automatic model_step();
        logic [7:0] n_in, n_out, n_upd;
        bit st, wr;
        if (rst) begin
            m_in = '0; m_out = '0; m_upd = '0;
            return;
        end
        st = run_en && !shift_en && !capture_en;
        n_in = m_in; n_out = m_out; n_upd = m_upd; wr = 0;
        if (shift_en) begin
            n_out = {tdi, m_out[7:1]};
            n_in  = {m_out[0], m_in[7:1]};
        end else if (capture_en) begin
            n_in = sys_in; n_out = sys_out;
        end else if (st) begin
            case (mode)
                3'd2: begin n_in = sys_in; n_out = ~m_out; wr = 1; end
                3'd3: n_in = f_sig(m_in, sys_in, sig_mask);
                3'd4: begin n_out = f_prpg(m_out); wr = 1; end
                3'd5: begin n_out = m_out + 8'd1; wr = 1; end
                3'd6: begin n_in = f_sig(m_in, sys_in, sig_mask); n_out = m_out + 8'd1; wr = 1; end
                default: ;
            endcase
        end
        if (wr) n_upd = n_out;
        else if (update_en) n_upd = m_out;
        m_in = n_in; m_out = n_out; m_upd = n_upd;
    endtask

    task automatic cyc();
        @(negedge clk);
        if (mdl_ok) begin
            chk(tag, {8'h0, pin_out}, {8'h0, forcing(mode) ? m_upd : sys_out});
            chk("R2", {15'h0, tdo}, {15'h0, m_in[0]});
        end
        @(posedge clk);
        model_step();
        mdl_ok = 1;
        #2;
    endtask

    task automatic idle();
        shift_en = 0; capture_en = 0; update_en = 0; run_en = 0; tdi = 0;
    endtask

    task automatic shift_word(input logic [15:0] v);
        idle();
        shift_en = 1;
        for (int i = 0; i < 16; i++) begin tdi = v[i]; cyc(); end
        idle();
    endtask

    task automatic read_word(output logic [15:0] v);
        idle();
        shift_en = 1;
        for (int i = 0; i < 16; i++) begin #1 v[i] = tdo; cyc(); end
        idle();
    endtask

    task automatic do_reset();
        idle(); rst = 1; cyc(); cyc(); rst = 0;
    endtask

    task automatic sig_run(input logic [7:0] seq [10], input logic [7:0] mk, output logic [7:0] sig);
        logic [15:0] w;
        do_reset();
        mode = 3'd3; sig_mask = mk; run_en = 1;
        for (int j = 0; j < 10; j++) begin sys_in = seq[j]; cyc(); end
        run_en = 0;
        read_word(w);
        sig = w[7:0];
    endtask

    initial begin
        #4_000_000;
        nerr++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [7:0] seq [10];
        logic [7:0] s0, s1, s2, ref_sig;
        int first;
        void'($urandom(32'd1234));
        mode = 3'd0; sys_in = 8'h00; sys_out = 8'h00; sig_mask = 8'h00;
        idle();
        rst = 1;
        cyc(); cyc();
        rst = 0;

        // R1: reset state
        tag = "R1";
        sys_out = 8'h3E; #1;
        chk("R1", {8'h0, pin_out}, 16'h003E);
        chk("R1", {15'h0, tdo}, 16'h0);
        mode = 3'd3; #1;
        chk("R1", {8'h0, pin_out}, 16'h0000);
        read_word(w);
        chk("R1", w, 16'h0000);

        // R2: chain order
        tag = "R2"; mode = 3'd0;
        shift_word(16'hA5C3);
        read_word(w);
        chk("R2", w, 16'hA5C3);

        // R3: capture
        tag = "R3";
        sys_in = 8'h3C; sys_out = 8'h96; capture_en = 1; cyc(); idle();
        read_word(w);
        chk("R3", w, 16'h963C);

        // R4: update drives forced pins
        tag = "R4";
        shift_word(16'h5A00);
        update_en = 1; cyc(); idle();
        mode = 3'd3; #1;
        chk("R4", {8'h0, pin_out}, 16'h005A);

        // R5: pass-through modes, run steps inert
        tag = "R5";
        sys_out = 8'h11; mode = 3'd0; #1;
        chk("R5", {8'h0, pin_out}, 16'h0011);
        mode = 3'd7; #1;
        chk("R5", {8'h0, pin_out}, 16'h0011);
        mode = 3'd1; run_en = 1; sys_in = 8'hFF;
        cyc(); cyc(); cyc(); idle();
        read_word(w);
        chk("R5", w, 16'h5A00);

        // R6: toggle
        tag = "R6";
        shift_word(16'h5A00);
        update_en = 1; cyc(); idle();
        mode = 3'd2; sys_in = 8'h77; run_en = 1;
        cyc(); chk("R6", {8'h0, pin_out}, 16'h00A5);
        cyc(); chk("R6", {8'h0, pin_out}, 16'h005A);
        idle();
        read_word(w);
        chk("R6", w, 16'h5A77);

        // R7: signature with mask
        tag = "R7";
        for (int j = 0; j < 10; j++) seq[j] = 8'($urandom);
        ref_sig = 8'h00;
        for (int j = 0; j < 10; j++) ref_sig = f_sig(ref_sig, seq[j], 8'h0F);
        sig_run(seq, 8'h0F, s0);
        chk("R7", {8'h0, s0}, {8'h0, ref_sig});
        seq[3] = seq[3] ^ 8'h01;
        sig_run(seq, 8'h0F, s1);
        chk("R7", {8'h0, s1}, {8'h0, s0});
        seq[3] = seq[3] ^ 8'h80;
        sig_run(seq, 8'h0F, s2);
        chk("R7", {15'h0, s2 != s0}, 16'h1);

        // R8: pattern generator period
        tag = "R8";
        mode = 3'd0;
        shift_word(16'h0100);
        mode = 3'd4; run_en = 1;
        cyc();
        chk("R8", {8'h0, pin_out}, 16'h0002);
        first = 0;
        for (int k = 2; k <= 255; k++) begin
            cyc();
            if (pin_out == 8'h01 && first == 0) first = k;
        end
        chk("R8", 16'(first), 16'd255);
        idle();

        // R9: count wrap
        tag = "R9";
        mode = 3'd0;
        shift_word(16'hFE00);
        mode = 3'd5; run_en = 1;
        cyc(); chk("R9", {8'h0, pin_out}, 16'h00FF);
        cyc(); chk("R9", {8'h0, pin_out}, 16'h0000);

        // R12: no strobe, hold
        tag = "R12";
        idle();
        cyc(); cyc(); cyc();
        chk("R12", {8'h0, pin_out}, 16'h0000);

        // R11: shift and capture outrank run
        tag = "R11";
        run_en = 1; shift_en = 1; tdi = 1;
        cyc();
        chk("R11", {8'h0, pin_out}, 16'h0000);
        shift_en = 0; capture_en = 1; sys_in = 8'hC5; sys_out = 8'h0F;
        cyc();
        chk("R11", {8'h0, pin_out}, 16'h0000);
        idle();
        read_word(w);
        chk("R11", w, 16'h0FC5);

        // R10: combined signature and count
        tag = "R10";
        do_reset();
        shift_word(16'h1000);
        mode = 3'd6; sig_mask = 8'h00; run_en = 1;
        ref_sig = 8'h00;
        for (int j = 0; j < 6; j++) begin
            sys_in = 8'($urandom);
            ref_sig = f_sig(ref_sig, sys_in, 8'h00);
            cyc();
        end
        idle();
        chk("R10", {8'h0, pin_out}, 16'h0016);
        read_word(w);
        chk("R10", w, {8'h16, ref_sig});

        // random mix against the model
        for (int n = 0; n < 3000; n++) begin
            mode       = 3'($urandom_range(0, 7));
            shift_en   = ($urandom_range(0, 99) < 15);
            capture_en = ($urandom_range(0, 99) < 10);
            update_en  = ($urandom_range(0, 99) < 15);
            run_en     = ($urandom_range(0, 99) < 60);
            tdi        = 1'($urandom);
            sys_in     = 8'($urandom);
            sys_out    = 8'($urandom);
            sig_mask   = 8'($urandom);
            rst        = ($urandom_range(0, 999) < 3);
            case (mode)
                3'd2: tag = "R6";
                3'd3: tag = "R7";
                3'd4: tag = "R8";
                3'd5: tag = "R9";
                3'd6: tag = "R10";
                default: tag = "R5";
            endcase
            cyc();
        end
        rst = 0; idle();
        cyc();

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule